// File: doc/BRIEF.md
# Packed-Pixel Video Scanout with Colour Lookup

This block drives a raster display of 640 by 400 visible pixels. It generates the line and frame timing and reads 32-bit words from video memory through a read port with a fixed latency. Each word holds eight 4-bit colour indices. The leftmost pixel is in the top nibble and the rightmost is in the bottom nibble. Each index selects one of sixteen 12-bit entries in a programmable colour table, and the result is driven out as 4-bit red, green and blue beside the two sync signals.

Memory is linear. Within a row the word address rises by one. Each row starts H_ACTIVE/8 words after the row above it, so with the default parameters row n starts at word 80·n. The block asks for each word early enough that the pixel stream has no gaps. It then delays the sync and blanking information by the same number of cycles, so every output describes the same screen position. The colour table can be rewritten through a simple write port at any time. A vertical-blank flag is exported for software that wants to update the picture between frames.

Top module: `pixel_scanout`

## Requirements
- R1: Within a fetched word, pixel k of the group of eight (k = 0 leftmost) takes its colour index from bits [31-4k : 28-4k], so bits 31:28 are shown first and bits 3:0 last.
- R2: A memory read is requested exactly once per group of eight visible pixels, in the scan cycle of the group's first pixel, at word address row·(H_ACTIVE/8) + column/8. No read is requested in two consecutive cycles, and successive reads within a row differ by one.
- R3: All outputs for one screen position appear together, MEM_LAT+1 cycles after the cycle in which that position is scanned. Read data must arrive on mem_rdata exactly MEM_LAT cycles after its request.
- R4: A line is H_ACTIVE+H_FP+H_SYNC+H_BP clocks long (640/16/96/48 by default). hsync_n_o is low (active) for exactly H_SYNC clocks, starting at column H_ACTIVE+H_FP.
- R5: A frame is V_ACTIVE+V_FP+V_SYNC+V_BP lines long (400/12/2/35 by default). vsync_o is high (active) on lines V_ACTIVE+V_FP through V_ACTIVE+V_FP+V_SYNC-1, and only while vblank_o is high.
- R6: red_o, green_o and blue_o are all zero for every position outside the visible area, in both the horizontal and the vertical blanking intervals.
- R7: vblank_o is high exactly on lines V_ACTIVE and above. It is aligned with the other outputs and rises at the start of a line, while hsync_n_o is high.
- R8: A visible pixel with index i shows colour table entry i, where the entry is {red[11:8], green[7:4], blue[3:0]}.
- R9: All sixteen table entries are zero after reset. A write (pal_we high at a clock edge, pal_sel selecting the entry) can happen at any time and applies to every pixel whose output is registered at a later edge.
- R10: While rst is high, the outputs sit at the blank state (RGB zero, hsync_n_o high, vsync_o low, vblank_o high) and no read is requested. The first clock after rst falls scans column 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Video memory read request |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_rdata | input | 32 | Read data, valid MEM_LAT cycles after the request |
| pal_we | input | 1 | Colour table write strobe |
| pal_sel | input | 4 | Colour table entry to write |
| pal_data | input | 12 | New entry value {r,g,b} |
| red_o | output | 4 | Red intensity |
| green_o | output | 4 | Green intensity |
| blue_o | output | 4 | Blue intensity |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| vblank_o | output | 1 | High during vertical blanking |

## Verification
After reset is released, the bench counts clock edges. Scan position p is taken to be edge count minus one. A read request for that position is compared in the same cycle. The colour, sync and blank outputs for that position are compared MEM_LAT+1 cycles later. Every comparison is made on the falling edge, after the registers that feed that output have settled. A colour table write is credited to the bench's model only from the falling edge after the write edge onward, which is the first cycle whose output register loaded after the write.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb12_t;

    // Position information carried alongside the pixel data.
    typedef struct packed {
        logic       active;
        logic [2:0] phase;
        logic       hsync_n;
        logic       vsync;
        logic       vblank;
    } beam_t;

    localparam beam_t BEAM_IDLE = '{active: 1'b0, phase: 3'd0,
                                    hsync_n: 1'b1, vsync: 1'b0, vblank: 1'b1};

    localparam int PIX_PER_WORD = 8;

    // Nibble k counted from the most significant end.
    function automatic logic [3:0] pick_nibble(input logic [31:0] w, input logic [2:0] k);
        return w[5'd31 - {k, 2'b00} -: 4];
    endfunction

endpackage

// File: rtl/scan_timing.sv
module scan_timing
    import vscan_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 400,
    parameter int V_FP     = 12,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 35,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output beam_t             beam,
    output logic              req,
    output logic [ADDR_W-1:0] req_addr
);
    localparam int H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
    localparam int V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
    localparam int HCW     = $clog2(H_TOTAL);
    localparam int VCW     = $clog2(V_TOTAL);
    localparam int WPR     = H_ACTIVE / PIX_PER_WORD;

    localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOTAL - 1);
    localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOTAL - 1);
    localparam logic [HCW-1:0] H_VIS    = HCW'(H_ACTIVE);
    localparam logic [HCW-1:0] HS_START = HCW'(H_ACTIVE + H_FP);
    localparam logic [HCW-1:0] HS_END   = HCW'(H_ACTIVE + H_FP + H_SYNC);
    localparam logic [VCW-1:0] V_VIS    = VCW'(V_ACTIVE);
    localparam logic [VCW-1:0] VS_START = VCW'(V_ACTIVE + V_FP);
    localparam logic [VCW-1:0] VS_END   = VCW'(V_ACTIVE + V_FP + V_SYNC);

    logic [HCW-1:0]    hcnt;
    logic [VCW-1:0]    vcnt;
    logic [ADDR_W-1:0] row_base;

    // Reset parks the beam on the last (blank) position of the frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt     <= H_LAST;
            vcnt     <= V_LAST;
            row_base <= '0;
        end else if (hcnt == H_LAST) begin
            hcnt <= '0;
            if (vcnt == V_LAST) begin
                vcnt     <= '0;
                row_base <= '0;
            end else begin
                vcnt     <= vcnt + 1'b1;
                row_base <= row_base + ADDR_W'(WPR);
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        beam.active  = (hcnt < H_VIS) && (vcnt < V_VIS);
        beam.phase   = hcnt[2:0];
        beam.hsync_n = !((hcnt >= HS_START) && (hcnt < HS_END));
        beam.vsync   = (vcnt >= VS_START) && (vcnt < VS_END);
        beam.vblank  = (vcnt >= V_VIS);
        req          = beam.active && (hcnt[2:0] == 3'd0);
        req_addr     = row_base + ADDR_W'(hcnt >> 3);
    end

endmodule

// File: rtl/fetch_align.sv
module fetch_align
    import vscan_pkg::*;
#(
    parameter int MEM_LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  beam_t       beam_in,
    input  logic [31:0] mem_rdata,
    output beam_t       beam_out,
    output logic [3:0]  pix_idx
);
    beam_t       stage [MEM_LAT];
    logic [31:0] word_q;
    logic        load;

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= BEAM_IDLE;
        else     stage[0] <= beam_in;
    end

    for (genvar g = 1; g < MEM_LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage[g] <= BEAM_IDLE;
            else     stage[g] <= stage[g-1];
        end
    end

    assign beam_out = stage[MEM_LAT-1];
    assign load     = beam_out.active && (beam_out.phase == 3'd0);

    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= mem_rdata;
    end

    // The first pixel of a group is taken straight from the returning data.
    assign pix_idx = load ? pick_nibble(mem_rdata, 3'd0)
                          : pick_nibble(word_q, beam_out.phase);

endmodule

// File: rtl/color_lut.sv
module color_lut
    import vscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pal_we,
    input  logic [3:0] pal_sel,
    input  logic [11:0] pal_data,
    input  beam_t      beam_in,
    input  logic [3:0] pix_idx,
    output rgb12_t     rgb,
    output logic       hsync_n,
    output logic       vsync,
    output logic       vblank
);
    rgb12_t table_q [16];

    for (genvar e = 0; e < 16; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)                                   table_q[e] <= '0;
            else if (pal_we && (pal_sel == 4'(e)))     table_q[e] <= rgb12_t'(pal_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb     <= '0;
            hsync_n <= 1'b1;
            vsync   <= 1'b0;
            vblank  <= 1'b1;
        end else begin
            rgb     <= beam_in.active ? table_q[pix_idx] : '0;
            hsync_n <= beam_in.hsync_n;
            vsync   <= beam_in.vsync;
            vblank  <= beam_in.vblank;
        end
    end

endmodule

// File: rtl/pixel_scanout.sv
module pixel_scanout
    import vscan_pkg::*;
#(
    parameter int H_ACTIVE = 640,
    parameter int H_FP     = 16,
    parameter int H_SYNC   = 96,
    parameter int H_BP     = 48,
    parameter int V_ACTIVE = 400,
    parameter int V_FP     = 12,
    parameter int V_SYNC   = 2,
    parameter int V_BP     = 35,
    parameter int MEM_LAT  = 2,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    input  logic              pal_we,
    input  logic [3:0]        pal_sel,
    input  logic [11:0]       pal_data,
    output logic [3:0]        red_o,
    output logic [3:0]        green_o,
    output logic [3:0]        blue_o,
    output logic              hsync_n_o,
    output logic              vsync_o,
    output logic              vblank_o
);
    beam_t      beam_now;
    beam_t      beam_late;
    logic [3:0] idx;
    rgb12_t     rgb;

    scan_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .ADDR_W(ADDR_W)
    ) u_timing (
        .clk(clk), .rst(rst), .beam(beam_now),
        .req(mem_rd_en), .req_addr(mem_addr)
    );

    fetch_align #(.MEM_LAT(MEM_LAT)) u_fetch (
        .clk(clk), .rst(rst), .beam_in(beam_now), .mem_rdata(mem_rdata),
        .beam_out(beam_late), .pix_idx(idx)
    );

    color_lut u_lut (
        .clk(clk), .rst(rst), .pal_we(pal_we), .pal_sel(pal_sel),
        .pal_data(pal_data), .beam_in(beam_late), .pix_idx(idx),
        .rgb(rgb), .hsync_n(hsync_n_o), .vsync(vsync_o), .vblank(vblank_o)
    );

    assign red_o   = rgb.r;
    assign green_o = rgb.g;
    assign blue_o  = rgb.b;

endmodule

// File: rtl/pixel_scanout_chk.sv
module pixel_scanout_chk #(
    parameter int H_SYNC = 96,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        red_o,
    input logic [3:0]        green_o,
    input logic [3:0]        blue_o,
    input logic              hsync_n_o,
    input logic              vsync_o,
    input logic              vblank_o
);
    logic [31:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || hsync_n_o) low_run <= '0;
        else                  low_run <= low_run + 1'b1;
    end

    // R2: reads never in consecutive cycles
    a_r2_spaced_reads: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    // R2: reads eight cycles apart step the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en && $past(mem_rd_en, 8)) |-> (mem_addr == $past(mem_addr, 8) + 1'b1));

    // R4: sync pulse width
    a_r4_hsync_width: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync_n_o) |-> (low_run == 32'(H_SYNC)));

    // R5: vertical sync lies inside vertical blanking
    a_r5_vsync_in_vblank: assert property (@(posedge clk) disable iff (rst)
        vsync_o |-> vblank_o);

    // R6: black during vertical blanking
    a_r6_black_in_vblank: assert property (@(posedge clk) disable iff (rst)
        vblank_o |-> ({red_o, green_o, blue_o} == 12'h000));

    // R7: blanking starts at a line start, outside the sync pulse
    a_r7_vblank_at_line_start: assert property (@(posedge clk) disable iff (rst)
        $rose(vblank_o) |-> hsync_n_o);

endmodule

bind pixel_scanout pixel_scanout_chk #(.H_SYNC(H_SYNC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_n_o(hsync_n_o), .vsync_o(vsync_o), .vblank_o(vblank_o)
);

// File: tb/pixel_scanout_tb.sv
`timescale 1ns/1ps
module pixel_scanout_tb;
    localparam int HA = 32, HFP = 2, HS = 3, HBP = 3;
    localparam int VA = 3, VFP = 1, VS = 1, VBP = 1;
    localparam int LAT = 2, AW = 16;
    localparam int HT = HA + HFP + HS + HBP;
    localparam int VT = VA + VFP + VS + VBP;
    localparam int WPR = HA / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          pal_we = 1'b0;
    logic [3:0]    pal_sel = '0;
    logic [11:0]   pal_data = '0;
    logic [3:0]    red_o, green_o, blue_o;
    logic          hsync_n_o, vsync_o, vblank_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [11:0] pal_m [16];
    logic [31:0] mpipe [LAT];

    always #2 clk = ~clk;

    pixel_scanout #(
        .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
        .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
        .MEM_LAT(LAT), .ADDR_W(AW)
    ) u_dut (
        .clk(clk), .rst(rst), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pal_we(pal_we), .pal_sel(pal_sel),
        .pal_data(pal_data), .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
        .hsync_n_o(hsync_n_o), .vsync_o(vsync_o), .vblank_o(vblank_o)
    );

    function automatic logic [31:0] wpat(input int a);
        return (32'(a) * 32'h9E37_79B1) ^ 32'h5A3C_0F96;
    endfunction

    // Fixed-latency memory model.
    always @(posedge clk) begin
        mpipe[0] <= mem_rd_en ? wpat(int'(mem_addr)) : 32'hDEAD_BEEF;
        for (int i = 1; i < LAT; i++) mpipe[i] <= mpipe[i-1];
    end
    assign mem_rdata = mpipe[LAT-1];

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
        end
    endtask

    // Compare every port against the model for the current cycle.
    task automatic check_now();
        int p, l, h, v, wa;
        bit act;
        logic [11:0] ergb;
        logic [3:0] idx;
        // request side: scan position p = cyc - 1
        p = cyc - 1;
        if (p < 0) begin
            chk(mem_rd_en == 1'b0, "R10 no read in reset", 32'(mem_rd_en), 0);
        end else begin
            h = p % HT; v = (p / HT) % VT;
            act = (h < HA) && (v < VA);
            chk(mem_rd_en == (act && (h % 8 == 0)), "R2 read strobe", 32'(mem_rd_en), 32'(act && (h % 8 == 0)));
            if (act && (h % 8 == 0))
                chk(int'(mem_addr) == v * WPR + h / 8, "R2 read address", 32'(mem_addr), 32'(v * WPR + h / 8));
        end
        // output side: position shown is p - LAT - 1
        l = cyc - (LAT + 2);
        if (l < 0) begin
            chk({red_o, green_o, blue_o, hsync_n_o, vsync_o, vblank_o} == {12'h0, 3'b101},
                "R10 blank state", {17'h0, red_o, green_o, blue_o, hsync_n_o, vsync_o, vblank_o}, 32'h5);
        end else begin
            h = l % HT; v = (l / HT) % VT;
            act = (h < HA) && (v < VA);
            if (act) begin
                wa = v * WPR + h / 8;
                idx = 4'(wpat(wa) >> (28 - 4 * (h % 8)));
                ergb = pal_m[idx];
                chk({red_o, green_o, blue_o} == ergb, "R1/R3/R8 pixel colour",
                    32'({red_o, green_o, blue_o}), 32'(ergb));
            end else begin
                chk({red_o, green_o, blue_o} == 12'h0, "R6 blanking black",
                    32'({red_o, green_o, blue_o}), 0);
            end
            chk(hsync_n_o == !((h >= HA + HFP) && (h < HA + HFP + HS)), "R4 hsync",
                32'(hsync_n_o), 32'(!((h >= HA + HFP) && (h < HA + HFP + HS))));
            chk(vsync_o == ((v >= VA + VFP) && (v < VA + VFP + VS)), "R5 vsync",
                32'(vsync_o), 32'((v >= VA + VFP) && (v < VA + VFP + VS)));
            chk(vblank_o == (v >= VA), "R7 vblank", 32'(vblank_o), 32'(v >= VA));
        end
    endtask

    task automatic scan(input int n);
        repeat (n) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic pal_write(input int e, input logic [11:0] val);
        @(negedge clk);
        pal_we = 1'b1; pal_sel = 4'(e); pal_data = val;
        @(negedge clk);
        pal_we = 1'b0;
        pal_m[e] = val;
    endtask

    // R10: state held in reset
    task automatic t_reset();
        repeat (3) begin
            @(negedge clk);
            check_now();
        end
    endtask

    // R9: zero table after reset, so every visible pixel is black
    task automatic t_zero_table();
        @(negedge clk);
        rst = 1'b0;
        check_now();
        scan(2 * HT);
    endtask

    // R8/R1: load a distinct colour into each entry and scan two frames
    task automatic t_load_table();
        for (int e = 0; e < 16; e++) pal_write(e, {4'(e), ~4'(e), 4'(e) ^ 4'h9});
        scan(2 * HT * VT);
    endtask

    // R9: rewrite entries during visible scan
    task automatic t_live_update();
        scan(HT + 5);
        pal_write(5, 12'hF0A);
        scan(HT);
        pal_write(0, 12'h3C7);
        pal_write(15, 12'h001);
        scan(HT * VT + 7);
    endtask

    initial begin
        for (int e = 0; e < 16; e++) pal_m[e] = 12'h000;
        t_reset();
        t_zero_table();
        t_load_table();
        t_live_update();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule